// File: doc/BRIEF.md
# Multi-Channel Slow-Clock Deglitcher

This block conditions a set of slow, active-high, asynchronous status lines, such as a wake request or a power-fail flag, before the rest of a chip acts on them. All channels are sampled together on a strobe that fires once every `DIV` cycles of a 32.768 kHz real-time clock. With the default `DIV = 2`, this gives a 16.384 kHz sample rate.

A channel's output rises only after its input has been seen high on two consecutive sample edges. This rejects short glitches and single stray samples. Once an output has risen, it stays high until a sample edge finds the input low. Every accepted pulse therefore lasts at least one full sample period, which is about 61 µs at the default rate.

The block has six channels. In index order they are: wake request, battery change, power fail, user reset, media change, and a precombined low-battery term. The logic that forms the low-battery term lies outside this block, and so does everything that consumes the cleaned outputs.

Top module: `slow_deglitcher`

## Requirements
- R1: The six channels are independent. Bit 0 is wake request, bit 1 battery change, bit 2 power fail, bit 3 user reset, bit 4 media change and bit 5 low battery. Each output depends only on the input bit of the same index.
- R2: `sample_stb` is high for exactly one clock cycle out of every `DIV` (2) cycles. It first goes high in the cycle after the first rising edge that follows reset release. The rising edges that end a strobe-high cycle are the sample edges.
- R3: An output rises only at a sample edge where its input is high, and only if the input was also high at the previous sample edge.
- R4: Once high, an output stays high until a sample edge at which its input is low. The minimum high time is one sample period (`DIV` clock cycles).
- R5: Outputs change only at sample edges. Input activity between sample edges has no effect on the outputs until the next sample edge.
- R6: An input pulse that rises and falls entirely between two sample edges never appears at the output.
- R7: An input that is high at exactly one sample edge, and low at the sample edges on either side, leaves its output low.
- R8: Synchronous active-high reset clears every output, `sample_stb` and all internal sample history, whatever the inputs are doing.
- R9: When an input is high at two consecutive sample edges, the output is high directly after the second of those edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rtc | input | 1 | 32.768 kHz real-time clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | NUM_CH (6) | Raw active-high asynchronous inputs, one bit per channel |
| sample_stb | output | 1 | Registered sample strobe, one cycle in every DIV |
| clean_out | output | NUM_CH (6) | Registered, deglitched channel outputs |

## Verification
The bench builds the block with its defaults: six channels, a divide-by-two strobe and two-sample acceptance. This small configuration allows a full sweep. Every ordered pair of 6-bit input vectors is applied on consecutive sample edges, so all four sample histories occur on every channel, and every channel is paired with every state of its neighbours. Directed sequences then place pulses between sample edges, at a single sample edge, and across two sample edges, and they assert inputs during reset. These cover glitch rejection, the exact rise cycle and the minimum pulse width.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;

  localparam int NUM_CHANNELS = 6;

  // Channel positions in the input and output vectors
  typedef enum int unsigned {
    CH_WAKE     = 0,
    CH_BATT_CHG = 1,
    CH_PWR_FAIL = 2,
    CH_USER_RST = 3,
    CH_MEDIA    = 4,
    CH_LOW_BATT = 5
  } chan_e;

  function automatic int cnt_width(input int div);
    return (div > 2) ? $clog2(div) : 1;
  endfunction

endpackage

// File: rtl/sample_enable_gen.sv
module sample_enable_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic stb
);
  localparam int CW = deglitch_pkg::cnt_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] PRE  = CW'(DIV - 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      stb   <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      stb   <= (cnt_q == PRE);
    end
  end

endmodule

// File: rtl/deglitch_channel.sv
module deglitch_channel #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic dout
);
  localparam int HW = STAGES - 1;

  logic [HW-1:0] hist_q;
  logic [HW-1:0] hist_d;

  generate
    if (HW == 1) begin : g_single
      assign hist_d = din;
    end else begin : g_shift
      assign hist_d = {hist_q[HW-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      dout   <= 1'b0;
    end else if (en) begin
      hist_q <= hist_d;
      dout   <= din & (&hist_q);
    end
  end

endmodule

// File: rtl/slow_deglitcher.sv
module slow_deglitcher #(
  parameter int NUM_CH = deglitch_pkg::NUM_CHANNELS,
  parameter int DIV    = 2,
  parameter int STAGES = 2
) (
  input  logic              clk_rtc,
  input  logic              rst,
  input  logic [NUM_CH-1:0] raw_in,
  output logic              sample_stb,
  output logic [NUM_CH-1:0] clean_out
);

  sample_enable_gen #(.DIV(DIV)) u_stb (
    .clk (clk_rtc),
    .rst (rst),
    .stb (sample_stb)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      deglitch_channel #(.STAGES(STAGES)) u_ch (
        .clk  (clk_rtc),
        .rst  (rst),
        .en   (sample_stb),
        .din  (raw_in[i]),
        .dout (clean_out[i])
      );
    end
  endgenerate

endmodule

// File: rtl/slow_deglitcher_chk.sv
module slow_deglitcher_chk #(
  parameter int NUM_CH = 6
) (
  input logic              clk_rtc,
  input logic              rst,
  input logic [NUM_CH-1:0] raw_in,
  input logic              sample_stb,
  input logic [NUM_CH-1:0] clean_out
);

  AST_STB_SINGLE: assert property (@(posedge clk_rtc) disable iff (rst)
    sample_stb |=> !sample_stb); // R2

  AST_HOLD_OFF_STB: assert property (@(posedge clk_rtc) disable iff (rst)
    !$past(sample_stb) |-> $stable(clean_out)); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk_rtc)
    $past(rst) |-> (clean_out == '0 && !sample_stb)); // R8

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
      AST_RISE_NEEDS_INPUT: assert property (@(posedge clk_rtc) disable iff (rst)
        $rose(clean_out[i]) |-> $past(raw_in[i])); // R3

      AST_MIN_WIDTH: assert property (@(posedge clk_rtc) disable iff (rst)
        $rose(clean_out[i]) |=> clean_out[i]); // R4
    end
  endgenerate

endmodule

bind slow_deglitcher slow_deglitcher_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_rtc    (clk_rtc),
  .rst        (rst),
  .raw_in     (raw_in),
  .sample_stb (sample_stb),
  .clean_out  (clean_out)
);

// File: tb/slow_deglitcher_tb.sv
module slow_deglitcher_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam int DIV = 2;

  logic         clk_rtc = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] raw_in = '0;
  logic         sample_stb;
  logic [N-1:0] clean_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  slow_deglitcher u_dut (
    .clk_rtc    (clk_rtc),
    .rst        (rst),
    .raw_in     (raw_in),
    .sample_stb (sample_stb),
    .clean_out  (clean_out)
  );

  always #(CLK_PERIOD/2) clk_rtc = ~clk_rtc;

  // Expected values: edges counted since reset release; a sample edge is every DIV-th one
  int           edges;
  logic [N-1:0] prev_smp;
  logic [N-1:0] exp_out;

  always @(posedge clk_rtc) begin
    if (rst) begin
      edges    <= 0;
      prev_smp <= '0;
      exp_out  <= '0;
    end else begin
      edges <= edges + 1;
      if ((edges + 1) % DIV == 0) begin
        exp_out  <= raw_in & prev_smp;
        prev_smp <= raw_in;
      end
    end
  end

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at t=%0t", tag, act, exp, $time);
    end
  endtask

  // One clock cycle: wait for the falling edge, then check the strobe and the outputs
  task automatic tick(input string tag);
    logic exp_stb;
    @(negedge clk_rtc);
    exp_stb = !rst && (edges % DIV == DIV - 1);
    check("R2 strobe", {{(N-1){1'b0}}, sample_stb}, {{(N-1){1'b0}}, exp_stb});
    check(tag, clean_out, exp_out);
  endtask

  // Advance until the next rising edge is a sample edge
  task automatic align();
    tick("R5 align");
    while ((edges + 1) % DIV != 0) tick("R5 align");
  endtask

  task automatic hold_samples(input logic [N-1:0] v, input int n, input string tag);
    raw_in = v;
    for (int k = 0; k < n * DIV; k++) tick(tag);
  endtask

  initial begin
    // R8: reset with every input held high
    raw_in = '1;
    repeat (5) @(negedge clk_rtc);
    check("R8 outputs in reset", clean_out, '0);
    check("R8 strobe in reset", {{(N-1){1'b0}}, sample_stb}, '0);
    rst = 1'b0;
    raw_in = '0;
    @(negedge clk_rtc);
    check("R8 after release", clean_out, '0);
    check("R2 first strobe", {{(N-1){1'b0}}, sample_stb}, 6'b000001);

    // R1 R3 R4: every ordered pair of input vectors on consecutive samples
    align();
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        hold_samples(6'(a), 1, "R1/R3 sweep");
        hold_samples(6'(b), 1, "R1/R4 sweep");
      end
    end
    hold_samples('0, 2, "R4 release");
    check("R4 all low after release", clean_out, '0);

    // R6: pulse that rises and falls between two sample edges
    align();
    tick("R6");
    raw_in = '1;
    tick("R6");
    raw_in = '0;
    for (int k = 0; k < 6; k++) begin
      tick("R6 glitch");
      check("R6 glitch hidden", clean_out, '0);
    end

    // R7: high at exactly one sample edge
    align();
    hold_samples('1, 1, "R7");
    hold_samples('0, 3, "R7");
    check("R7 single sample rejected", clean_out, '0);

    // R9 R4: two high samples give exactly one sample period of output
    align();
    raw_in = 6'b101101;
    tick("R9");
    check("R9 not after first sample", clean_out, '0);
    tick("R9");
    tick("R9");
    check("R9 high after second sample", clean_out, 6'b101101);
    raw_in = '0;
    tick("R4");
    check("R4 still high mid period", clean_out, 6'b101101);
    tick("R4");
    check("R4 low after low sample", clean_out, '0);

    // R5: mid-period input change does not move outputs
    align();
    hold_samples(6'b010010, 2, "R5");
    tick("R5");
    raw_in = '0;
    tick("R5");
    check("R5 held across non-sample edge", clean_out, 6'b010010);

    // R8: reset in the middle of activity
    hold_samples('1, 3, "R8");
    rst = 1'b1;
    tick("R8 mid reset");
    check("R8 cleared mid run", clean_out, '0);
    rst = 1'b0;
    raw_in = '0;
    tick("R8 resume");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule